// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block drives the three status LEDs of a 10/100 Ethernet physical layer: link, speed and activity. All three outputs are active low, so a 0 lights the LED. The link LED and the speed LED follow the link and line-rate inputs directly. The activity LED is driven by a small state machine. Each qualifying transmit or receive strobe starts a stretch window, or restarts it if it is already running. While the window is open the LED alternates between lit and dark on a fixed half-period. Under heavy traffic the window never closes, so the LED flickers steadily. Isolated packets give short bursts of blinking.

In wake-on-LAN mode, a strobe counts only when the packet-class flags that come with it qualify. With the filter bit at 0, broadcast packets and packets that match the individual address both count. With the filter bit at 1, only address-match packets count. Address matching is done elsewhere; this block only reads its result flags.

The activity state machine has three states:
- `ST_IDLE`: LED dark, timers cleared.
- `ST_LIT`: LED lit.
- `ST_DARK`: LED dark inside an open window.

It has these transitions:
- *kick*: `ST_IDLE` to `ST_LIT` on a qualifying event.
- *flip*: `ST_LIT` to `ST_DARK`, or back, when the phase counter reaches `HALF_CYC-1`.
- *expire*: either running state to `ST_IDLE` when the stretch counter is 0 and no event arrives.
- *drop*: any state to `ST_IDLE` when the link is down.

Top module: `phy_led_ctrl`

## Requirements
- R1: During reset and after it is released, before any other stimulus, `led_link_n`, `led_speed_n` and `led_act_n` are all 1 (dark).
- R2: `led_link_n` equals the inverse of `link_up`, registered one clock later, at either speed.
- R3: `led_speed_n` equals the inverse of `speed_100`, registered one clock later. It is 0 when `speed_100` is 1 (100 Mb/s) and 1 when `speed_100` is 0 (10 Mb/s).
- R4: When no qualifying event has occurred within the last `STRETCH_CYC` clocks, `led_act_n` is 1.
- R5: A qualifying event seen at a clock edge while the machine is idle drives `led_act_n` to 0 from that same edge.
- R6: While the stretch window is open, `led_act_n` toggles every `HALF_CYC` clocks. Events during the window do not reset this phase.
- R7: Each qualifying event reloads the stretch window to `STRETCH_CYC` clocks (default 65536). The LED returns to dark and idle `STRETCH_CYC` clocks after the last event.
- R8: With `wol_mode`=1 and `wol_ucast_only`=0, a strobe counts when `pkt_bcast` or `pkt_uamatch` is 1.
- R9: With `wol_mode`=1 and `wol_ucast_only`=1, a strobe counts only when `pkt_uamatch` is 1. A broadcast-only strobe leaves `led_act_n` at 1 when the machine is idle.
- R10: With `wol_mode`=0, any `tx_act` or `rx_act` strobe counts, whatever the packet-class flags.
- R11: While `link_up` is 0, events are ignored, `led_act_n` is 1 from the next edge on, and the stretch and phase timers are cleared. When the link returns without an event, the LED stays dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | 1 while a link is established |
| speed_100 | input | 1 | 1 at 100 Mb/s, 0 at 10 Mb/s |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| pkt_bcast | input | 1 | Current packet is a broadcast |
| pkt_uamatch | input | 1 | Current packet matches the individual address |
| wol_mode | input | 1 | Wake-on-LAN mode active |
| wol_ucast_only | input | 1 | In wake-on-LAN mode, count only address-match packets |
| led_link_n | output | 1 | Link LED, active low |
| led_speed_n | output | 1 | Speed LED, active low |
| led_act_n | output | 1 | Activity LED, active low |

## Verification
Directed sequences cover the following cases:
- A single strobe with no further traffic, which separates the blink phase from window expiry.
- Strobes spaced closer than the window, which show that a reload extends the window without re-phasing the blink.
- Broadcast-only strobes under both settings of the filter bit, which separate the two wake-on-LAN policies.
- A link drop in the middle of a window followed by a quiet return, which shows that the timers were cleared rather than paused.

Constrained random traffic then varies the strobe density, the packet flags, the mode, the filter bit and occasional link drops. It is compared cycle by cycle against a bench model of the requirements, which exposes off-by-one errors in the reload, toggle and expiry cycles under mixed load.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LIT  = 2'd1,
        ST_DARK = 2'd2
    } act_state_e;
endpackage

// File: rtl/act_qualify.sv
module act_qualify (
    input  logic link_up,
    input  logic tx_act,
    input  logic rx_act,
    input  logic pkt_bcast,
    input  logic pkt_uamatch,
    input  logic wol_mode,
    input  logic wol_ucast_only,
    output logic act_evt
);
    logic strobe;
    logic class_ok;

    always_comb begin
        strobe = tx_act | rx_act;
        if (!wol_mode)
            class_ok = 1'b1;
        else if (wol_ucast_only)
            class_ok = pkt_uamatch;
        else
            class_ok = pkt_uamatch | pkt_bcast;
        act_evt = link_up & strobe & class_ok;
    end
endmodule

// File: rtl/act_blink.sv
module act_blink
    import phy_led_pkg::*;
#(
    parameter int STRETCH_CYC = 65536,
    parameter int HALF_CYC    = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_up,
    input  logic       act_evt,
    output act_state_e state,
    output logic       led_act_n
);
    localparam int SW = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1;
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [SW-1:0] STRETCH_TOP = SW'(STRETCH_CYC - 1);
    localparam logic [HW-1:0] HALF_TOP    = HW'(HALF_CYC - 1);

    act_state_e    state_nxt;
    logic [SW-1:0] stretch_q;
    logic [HW-1:0] phase_q;
    logic          expire;
    logic          flip;

    always_comb begin
        expire    = !act_evt && (stretch_q == '0);
        flip      = (phase_q == HALF_TOP);
        state_nxt = state;
        if (!link_up) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (act_evt) state_nxt = ST_LIT;
                ST_LIT:  if (expire) state_nxt = ST_IDLE;
                         else if (flip) state_nxt = ST_DARK;
                ST_DARK: if (expire) state_nxt = ST_IDLE;
                         else if (flip) state_nxt = ST_LIT;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // stretch and phase timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stretch_q <= '0;
            phase_q   <= '0;
        end else if (state_nxt == ST_IDLE) begin
            stretch_q <= '0;
            phase_q   <= '0;
        end else if (state == ST_IDLE) begin
            stretch_q <= STRETCH_TOP;
            phase_q   <= '0;
        end else begin
            stretch_q <= act_evt ? STRETCH_TOP : stretch_q - 1'b1;
            phase_q   <= flip ? '0 : phase_q + 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) led_act_n <= 1'b1;
        else        led_act_n <= (state_nxt != ST_LIT);
    end
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
    import phy_led_pkg::*;
#(
    parameter int STRETCH_CYC = 65536,
    parameter int HALF_CYC    = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic speed_100,
    input  logic tx_act,
    input  logic rx_act,
    input  logic pkt_bcast,
    input  logic pkt_uamatch,
    input  logic wol_mode,
    input  logic wol_ucast_only,
    output logic led_link_n,
    output logic led_speed_n,
    output logic led_act_n
);
    logic       act_evt;
    act_state_e blink_state;

    act_qualify u_qual (
        .link_up        (link_up),
        .tx_act         (tx_act),
        .rx_act         (rx_act),
        .pkt_bcast      (pkt_bcast),
        .pkt_uamatch    (pkt_uamatch),
        .wol_mode       (wol_mode),
        .wol_ucast_only (wol_ucast_only),
        .act_evt        (act_evt)
    );

    act_blink #(
        .STRETCH_CYC (STRETCH_CYC),
        .HALF_CYC    (HALF_CYC)
    ) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .act_evt   (act_evt),
        .state     (blink_state),
        .led_act_n (led_act_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_link_n  <= 1'b1;
            led_speed_n <= 1'b1;
        end else begin
            led_link_n  <= ~link_up;
            led_speed_n <= ~speed_100;
        end
    end
endmodule

// File: rtl/phy_led_chk.sv
module phy_led_chk
    import phy_led_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       link_up,
    input logic       speed_100,
    input logic       pkt_uamatch,
    input logic       wol_mode,
    input logic       wol_ucast_only,
    input logic       act_evt,
    input act_state_e blink_state,
    input logic       led_link_n,
    input logic       led_speed_n,
    input logic       led_act_n
);
    a_r2_link_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (led_link_n == !$past(link_up)));

    a_r3_speed_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (led_speed_n == !$past(speed_100)));

    a_r11_link_down_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (led_act_n && blink_state == ST_IDLE));

    a_r5_kick_lights: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_state == ST_IDLE && act_evt) |=> !led_act_n);

    a_r9_ucast_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_state == ST_IDLE && wol_mode && wol_ucast_only && !pkt_uamatch) |=> led_act_n);

    a_r4_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_state == ST_IDLE) |-> led_act_n);
endmodule

bind phy_led_ctrl phy_led_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .link_up        (link_up),
    .speed_100      (speed_100),
    .pkt_uamatch    (pkt_uamatch),
    .wol_mode       (wol_mode),
    .wol_ucast_only (wol_ucast_only),
    .act_evt        (act_evt),
    .blink_state    (blink_state),
    .led_link_n     (led_link_n),
    .led_speed_n    (led_speed_n),
    .led_act_n      (led_act_n)
);

// File: tb/test_phy_led_ctrl.sv
module test_phy_led_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int S = 40;
    localparam int H = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic link_up = 0, speed_100 = 0, tx_act = 0, rx_act = 0;
    logic pkt_bcast = 0, pkt_uamatch = 0, wol_mode = 0, wol_ucast_only = 0;
    logic led_link_n, led_speed_n, led_act_n;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_led_ctrl #(.STRETCH_CYC(S), .HALF_CYC(H)) i_phy_led_ctrl (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .speed_100(speed_100),
        .tx_act(tx_act), .rx_act(rx_act), .pkt_bcast(pkt_bcast),
        .pkt_uamatch(pkt_uamatch), .wol_mode(wol_mode),
        .wol_ucast_only(wol_ucast_only), .led_link_n(led_link_n),
        .led_speed_n(led_speed_n), .led_act_n(led_act_n)
    );

    // requirement model: which strobes count (R8, R9, R10, R11)
    function automatic bit counts(bit lk, bit tx, bit rx, bit bc, bit ua, bit wm, bit uo);
        if (!lk || !(tx || rx)) return 0;
        if (!wm) return 1;
        return uo ? ua : (ua || bc);
    endfunction

    // requirement model of the activity window (R4..R7, R11)
    bit m_run, m_on;
    int m_st, m_ph;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run <= 0; m_on <= 0; m_st <= 0; m_ph <= 0;
        end else begin
            automatic bit ev = counts(link_up, tx_act, rx_act, pkt_bcast, pkt_uamatch, wol_mode, wol_ucast_only);
            if (!link_up) begin
                m_run <= 0; m_on <= 0; m_st <= 0; m_ph <= 0;
            end else if (!m_run) begin
                if (ev) begin m_run <= 1; m_on <= 1; m_st <= S-1; m_ph <= 0; end
            end else if (!ev && m_st == 0) begin
                m_run <= 0; m_on <= 0; m_ph <= 0;
            end else begin
                m_st <= ev ? S-1 : m_st-1;
                if (m_ph == H-1) begin m_on <= !m_on; m_ph <= 0; end
                else m_ph <= m_ph + 1;
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model(string tag);
        chk({tag, " act"}, led_act_n, !m_on);
        chk("R2 link", led_link_n, !link_up_q);
        chk("R3 speed", led_speed_n, !speed_q);
    endtask

    logic link_up_q = 0, speed_q = 0;
    always @(posedge clk) begin
        link_up_q <= rst_n ? link_up : 1'b0;
        speed_q   <= rst_n ? speed_100 : 1'b0;
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic strobe(bit bc, bit ua);
        rx_act = 1; pkt_bcast = bc; pkt_uamatch = ua;
        step();
        rx_act = 0; pkt_bcast = 0; pkt_uamatch = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        step(2);
        chk("R1 link", led_link_n, 1); chk("R1 speed", led_speed_n, 1); chk("R1 act", led_act_n, 1);
        rst_n = 1; step();
        chk("R1 link post", led_link_n, 1); chk("R1 act post", led_act_n, 1);

        link_up = 1; speed_100 = 1; step();
        chk("R2 link on", led_link_n, 0);
        chk("R3 speed 100", led_speed_n, 0);
        chk("R4 act idle", led_act_n, 1);
        speed_100 = 0; step();
        chk("R3 speed 10", led_speed_n, 1);
        chk("R2 link at 10", led_link_n, 0);

        // R10: plain strobe outside wake mode, flags ignored
        tx_act = 1; step(); tx_act = 0;
        chk("R10 strobe lights", led_act_n, 0);
        // R6: toggle after HALF cycles
        step(H-1); chk("R6 still lit", led_act_n, 0);
        step();    chk("R6 toggled dark", led_act_n, 1);
        step(H);   chk("R6 toggled lit", led_act_n, 0);
        // R7: expiry S clocks after last event
        step(S - 2*H + 2); chk("R7 expired", led_act_n, 1); cmp_model("R7");
        // R7: retrigger keeps window open
        strobe(0, 0); step(30); strobe(0, 0);
        for (int i = 0; i < 30; i++) begin cmp_model("R7 retrig"); step(); end
        step(S + 5); chk("R4 idle after window", led_act_n, 1);

        // R8: wake mode, filter bit 0, broadcast counts
        wol_mode = 1; wol_ucast_only = 0;
        strobe(1, 0); chk("R8 bcast lights", led_act_n, 0);
        step(S + 5);
        // R9: filter bit 1, broadcast ignored
        wol_ucast_only = 1;
        for (int i = 0; i < 10; i++) begin strobe(1, 0); chk("R9 bcast ignored", led_act_n, 1); end
        strobe(0, 1); chk("R9 uamatch lights", led_act_n, 0);

        // R11: link drop clears window
        step(2); link_up = 0; step();
        chk("R11 link dark", led_link_n, 1); chk("R11 act dark", led_act_n, 1);
        tx_act = 1; step(); tx_act = 0;
        chk("R11 event ignored", led_act_n, 1);
        link_up = 1;
        for (int i = 0; i < 8; i++) begin step(); chk("R11 stays dark", led_act_n, 1); end
        wol_mode = 0;

        // random traffic against the model
        for (int seg = 0; seg < 40; seg++) begin
            automatic int dens = $urandom_range(1, 60);
            wol_mode = $urandom_range(0, 2) == 0;
            wol_ucast_only = $urandom_range(0, 1);
            for (int c = 0; c < 80; c++) begin
                tx_act = ($urandom_range(0, 99) < dens);
                rx_act = ($urandom_range(0, 99) < dens/2);
                pkt_bcast = $urandom_range(0, 1);
                pkt_uamatch = $urandom_range(0, 3) == 0;
                if ($urandom_range(0, 199) == 0) link_up = !link_up;
                else if (!link_up && $urandom_range(0, 7) == 0) link_up = 1;
                if ($urandom_range(0, 99) == 0) speed_100 = !speed_100;
                step();
                cmp_model("R5 random");
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule